// File: doc/BRIEF.md
# PCIe Reset Release Sequencer

After power-on, a PCIe controller and its PHY stay in reset until something releases them in the right order. This block does that. It starts on a single start pulse. It first pulls the board-level fundamental reset pin low. It then raises the PHY and controller reset-release bits in a shared configuration register, one group at a time, and waits a fixed number of milliseconds after each of the first three groups. It lets the fundamental reset go and sets the last release bit. Finally it clears two receive-mixer bits in the receive control register of each of the two lanes.

Every register change travels over a simple message port. Each change is a read followed by a write of the modified value, so bits set by earlier steps and unrelated bits keep their values. The millisecond waits come from a down-counter. The counter is loaded with the wait length times the `CLK_PER_MS` parameter, so a small configuration can run the whole order in a few hundred cycles. When the last lane write is accepted, `done` goes high and stays high. Any later start pulse is ignored until the next reset.

Top module: `pcie_rst_seq`

## Requirements
- R1: Out of reset, `perst_n` is 1, `done` is 0 and `req_valid` is 0. This holds until `start` is seen.
- R2: After `start`, `perst_n` goes to 0 before the first port request. It stays 0 through the first three configuration writes.
- R3: Once `req_valid` is 1, it stays 1 with `req_write`, `req_port`, `req_addr` and `req_wdata` unchanged until a cycle with `ack` = 1. A read uses `req_write` = 0 and takes `rdata` in its ack cycle. A write uses `req_write` = 1.
- R4: Each configuration change reads `CFG_ADDR` on port `SOC_PORT` and writes back the value read ORed with new bits. The order is: bit 0 first, then bits 1 and 2 in one write, then bit 3, then bit 4. All other bits keep their read value.
- R5: Between the bit-0 write and the next request there are at least 1×`CLK_PER_MS` idle cycles. After the bits-1/2 write there are at least 80×`CLK_PER_MS`. After the bit-3 write there are at least 20×`CLK_PER_MS`. Each wait is at most a few cycles longer than its minimum.
- R6: `perst_n` returns to 1 after the 20 ms wait and before the read for the bit-4 step. It stays 1 from then on.
- R7: After the bit-4 write, the sequencer does a read-modify-write on `LANE0_ADDR` and then on `LANE1_ADDR`, both on port `AFE_PORT`. Each clears bits 6 and 7 and keeps all other bits.
- R8: `done` rises after the lane 1 write is accepted and stays high. After that no further requests are made, and a new `start` has no effect until reset.
- R9: The order and the data of all transactions do not depend on how many cycles `ack` is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| perst_n | output | 1 | Active-low fundamental reset to the board |
| req_valid | output | 1 | Message port request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_port | output | PORT_W | Destination port identifier |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | 32 | Write data |
| ack | input | 1 | Request accepted this cycle |
| rdata | input | 32 | Read data, valid with `ack` on a read |
| done | output | 1 | Sequence complete (sticky) |

## Verification
The bench replays the whole order with the acknowledge held off for zero to three cycles. It uses register start values chosen so that a missing OR, a wrong clear mask or a lost bit shows up as a wrong written word. A design that timed its waits from the wrong step, or used the wrong length, would show an idle gap outside the window for that step. A design that released the fundamental reset one step too early or too late would show the pin at the wrong level on the third or fourth read-modify-write pair. After `done`, the bench sends another start pulse. A design that re-armed on it would issue fresh requests.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   localparam int DATA_W = 32;
   localparam int MS_W   = 8;

   typedef enum logic [1:0] {
      SK_PIN_LOW,
      SK_PIN_HIGH,
      SK_SET,
      SK_CLR
   } step_kind_e;

   typedef enum logic [1:0] {
      TG_CFG,
      TG_LANE0,
      TG_LANE1
   } target_e;

   typedef struct packed {
      step_kind_e          kind;
      target_e             tgt;
      logic [DATA_W-1:0]   mask;
      logic [MS_W-1:0]     wait_ms;
   } step_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_STEP,
      SQ_RMW,
      SQ_WAIT,
      SQ_DONE
   } sq_state_e;

   typedef enum logic [1:0] {
      RM_IDLE,
      RM_RD,
      RM_WR
   } rm_state_e;

endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
   parameter int CLK_PER_MS = 100000,
   parameter int MAX_MS     = 80,
   parameter int MS_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MS_W-1:0] ms,
   output logic            busy
);

   localparam int CNT_W = $clog2(MAX_MS * CLK_PER_MS + 1) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic             busy_q;

   generate
      if (CLK_PER_MS == 1) begin : g_unit
         assign load_val = CNT_W'(ms);
      end else begin : g_scaled
         assign load_val = CNT_W'(ms) * CNT_W'(CLK_PER_MS);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= load_val - CNT_W'(1);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign busy = busy_q;

endmodule

// File: rtl/seq_rmw.sv
module seq_rmw
   import rst_seq_pkg::*;
#(
   parameter int PORT_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              clr_mode,
   input  logic [PORT_W-1:0] port_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              req_valid,
   output logic              req_write,
   output logic [PORT_W-1:0] req_port,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              ack,
   input  logic [DATA_W-1:0] rdata,
   output logic              done
);

   rm_state_e         st_q;
   logic              clr_q;
   logic [PORT_W-1:0] port_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q;
   logic [DATA_W-1:0] merged;

   assign merged = clr_q ? (rdata & ~mask_q) : (rdata | mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RM_IDLE;
         clr_q  <= 1'b0;
         port_q <= '0;
         addr_q <= '0;
         mask_q <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            RM_IDLE: if (go) begin
               clr_q  <= clr_mode;
               port_q <= port_i;
               addr_q <= addr_i;
               mask_q <= mask_i;
               st_q   <= RM_RD;
            end
            RM_RD: if (ack) begin
               data_q <= merged;
               st_q   <= RM_WR;
            end
            RM_WR: if (ack) begin
               done_q <= 1'b1;
               st_q   <= RM_IDLE;
            end
            default: st_q <= RM_IDLE;
         endcase
      end
   end

   assign req_valid = (st_q == RM_RD) || (st_q == RM_WR);
   assign req_write = (st_q == RM_WR);
   assign req_port  = port_q;
   assign req_addr  = addr_q;
   assign req_wdata = data_q;
   assign done      = done_q;

endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
   import rst_seq_pkg::*;
#(
   parameter int                 CLK_PER_MS   = 100000,
   parameter int                 PORT_W       = 8,
   parameter int                 ADDR_W       = 16,
   parameter logic [PORT_W-1:0]  SOC_PORT     = 8'h31,
   parameter logic [PORT_W-1:0]  AFE_PORT     = 8'h16,
   parameter logic [ADDR_W-1:0]  CFG_ADDR     = 16'h0073,
   parameter logic [ADDR_W-1:0]  LANE0_ADDR   = 16'h2080,
   parameter logic [ADDR_W-1:0]  LANE1_ADDR   = 16'h2180,
   parameter int                 LANE_RST_BIT = 0,
   parameter int                 PHY_SB_BIT   = 1,
   parameter int                 MAIN_BIT     = 2,
   parameter int                 CTL_SB_BIT   = 3,
   parameter int                 PRIM_BIT     = 4,
   parameter int                 MIX_LO_BIT   = 6,
   parameter int                 MIX_HI_BIT   = 7,
   parameter int                 WAIT_A_MS    = 1,
   parameter int                 WAIT_B_MS    = 80,
   parameter int                 WAIT_C_MS    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              perst_n,
   output logic              req_valid,
   output logic              req_write,
   output logic [PORT_W-1:0] req_port,
   output logic [ADDR_W-1:0] req_addr,
   output logic [31:0]       req_wdata,
   input  logic              ack,
   input  logic [31:0]       rdata,
   output logic              done
);

   localparam int NSTEPS = 8;
   localparam int IDX_W  = $clog2(NSTEPS);
   localparam int MAX_MS = (WAIT_A_MS > WAIT_B_MS)
                           ? ((WAIT_A_MS > WAIT_C_MS) ? WAIT_A_MS : WAIT_C_MS)
                           : ((WAIT_B_MS > WAIT_C_MS) ? WAIT_B_MS : WAIT_C_MS);
   localparam int CHK_BITS [7] = '{LANE_RST_BIT, PHY_SB_BIT, MAIN_BIT,
                                   CTL_SB_BIT, PRIM_BIT, MIX_LO_BIT, MIX_HI_BIT};
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (CLK_PER_MS < 1) begin : g_bad_rate
         $error("CLK_PER_MS must be at least 1");
      end
      if (MAX_MS >= (1 << MS_W) || WAIT_A_MS < 1 || WAIT_B_MS < 1 || WAIT_C_MS < 1)
      begin : g_bad_wait
         $error("wait lengths must lie in 1 .. 2**MS_W-1");
      end
      for (genvar b = 0; b < 7; b++) begin : g_bitchk
         if (CHK_BITS[b] < 0 || CHK_BITS[b] >= DATA_W) begin : g_bad_bit
            $error("bit position outside the data word");
         end
      end
   endgenerate

   function automatic step_t step_at(input logic [IDX_W-1:0] idx);
      step_t s;
      s = '{kind: SK_PIN_LOW, tgt: TG_CFG, mask: '0, wait_ms: '0};
      case (idx)
         3'd0: s.kind = SK_PIN_LOW;
         3'd1: begin
            s.kind = SK_SET; s.mask = ONE << LANE_RST_BIT;
            s.wait_ms = MS_W'(WAIT_A_MS);
         end
         3'd2: begin
            s.kind = SK_SET; s.mask = (ONE << PHY_SB_BIT) | (ONE << MAIN_BIT);
            s.wait_ms = MS_W'(WAIT_B_MS);
         end
         3'd3: begin
            s.kind = SK_SET; s.mask = ONE << CTL_SB_BIT;
            s.wait_ms = MS_W'(WAIT_C_MS);
         end
         3'd4: s.kind = SK_PIN_HIGH;
         3'd5: begin
            s.kind = SK_SET; s.mask = ONE << PRIM_BIT;
         end
         3'd6: begin
            s.kind = SK_CLR; s.tgt = TG_LANE0;
            s.mask = (ONE << MIX_LO_BIT) | (ONE << MIX_HI_BIT);
         end
         default: begin
            s.kind = SK_CLR; s.tgt = TG_LANE1;
            s.mask = (ONE << MIX_LO_BIT) | (ONE << MIX_HI_BIT);
         end
      endcase
      return s;
   endfunction

   sq_state_e         st_q;
   logic [IDX_W-1:0]  idx_q;
   logic              perst_q;
   logic              done_q;
   step_t             cur;
   logic              last_step;
   logic              rmw_go;
   logic              rmw_done;
   logic              tmr_load;
   logic              tmr_busy;
   logic [PORT_W-1:0] tgt_port;
   logic [ADDR_W-1:0] tgt_addr;

   assign cur       = step_at(idx_q);
   assign last_step = (idx_q == IDX_W'(NSTEPS - 1));
   assign rmw_go    = (st_q == SQ_STEP) && (cur.kind == SK_SET || cur.kind == SK_CLR);
   assign tmr_load  = (st_q == SQ_RMW) && rmw_done && (cur.wait_ms != '0);

   always_comb begin
      tgt_port = (cur.tgt == TG_CFG) ? SOC_PORT : AFE_PORT;
      case (cur.tgt)
         TG_LANE0: tgt_addr = LANE0_ADDR;
         TG_LANE1: tgt_addr = LANE1_ADDR;
         default:  tgt_addr = CFG_ADDR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         idx_q   <= '0;
         perst_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         case (st_q)
            SQ_IDLE: if (start) begin
               idx_q <= '0;
               st_q  <= SQ_STEP;
            end
            SQ_STEP: begin
               if (cur.kind == SK_PIN_LOW || cur.kind == SK_PIN_HIGH) begin
                  perst_q <= (cur.kind == SK_PIN_HIGH);
                  if (last_step) begin
                     st_q   <= SQ_DONE;
                     done_q <= 1'b1;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end else begin
                  st_q <= SQ_RMW;
               end
            end
            SQ_RMW: if (rmw_done) begin
               if (cur.wait_ms != '0) begin
                  st_q <= SQ_WAIT;
               end else if (last_step) begin
                  st_q   <= SQ_DONE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
                  st_q  <= SQ_STEP;
               end
            end
            SQ_WAIT: if (!tmr_busy) begin
               if (last_step) begin
                  st_q   <= SQ_DONE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
                  st_q  <= SQ_STEP;
               end
            end
            SQ_DONE: st_q <= SQ_DONE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   seq_ms_timer #(
      .CLK_PER_MS (CLK_PER_MS),
      .MAX_MS     (MAX_MS),
      .MS_W       (MS_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .ms    (cur.wait_ms),
      .busy  (tmr_busy)
   );

   seq_rmw #(
      .PORT_W (PORT_W),
      .ADDR_W (ADDR_W)
   ) u_rmw (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (rmw_go),
      .clr_mode  (cur.kind == SK_CLR),
      .port_i    (tgt_port),
      .addr_i    (tgt_addr),
      .mask_i    (cur.mask),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_port  (req_port),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .ack       (ack),
      .rdata     (rdata),
      .done      (rmw_done)
   );

   assign perst_n = perst_q;
   assign done    = done_q;

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
   parameter int                PORT_W       = 8,
   parameter int                ADDR_W       = 16,
   parameter logic [PORT_W-1:0] SOC_PORT     = 8'h31,
   parameter logic [PORT_W-1:0] AFE_PORT     = 8'h16,
   parameter logic [ADDR_W-1:0] CFG_ADDR     = 16'h0073,
   parameter int                LANE_RST_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              perst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [PORT_W-1:0] req_port,
   input logic [ADDR_W-1:0] req_addr,
   input logic [31:0]       req_wdata,
   input logic              ack,
   input logic              done
);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ack) |=> (req_valid && $stable(req_write) && $stable(req_port)
                               && $stable(req_addr) && $stable(req_wdata)));

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (perst_n && !req_valid));

   // R7
   lane_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_port == AFE_PORT) |-> perst_n);

   // R4
   cfg_keeps_lane_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_port == SOC_PORT && req_addr == CFG_ADDR)
         |-> req_wdata[LANE_RST_BIT]);

   // R2
   pin_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perst_n) |-> !req_valid);

endmodule

bind pcie_rst_seq rst_seq_chk #(
   .PORT_W       (PORT_W),
   .ADDR_W       (ADDR_W),
   .SOC_PORT     (SOC_PORT),
   .AFE_PORT     (AFE_PORT),
   .CFG_ADDR     (CFG_ADDR),
   .LANE_RST_BIT (LANE_RST_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .perst_n   (perst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_port  (req_port),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .ack       (ack),
   .done      (done)
);

// File: tb/pcie_rst_seq_tb.sv
module pcie_rst_seq_tb;

   localparam int          CPM   = 5;
   localparam logic [7:0]  SOCP  = 8'h31;
   localparam logic [7:0]  AFEP  = 8'h16;
   localparam logic [15:0] CFGA  = 16'h0073;
   localparam logic [15:0] L0A   = 16'h2080;
   localparam logic [15:0] L1A   = 16'h2180;
   localparam int          NTX   = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        perst_n, req_valid, req_write, done;
   logic [7:0]  req_port;
   logic [15:0] req_addr;
   logic [31:0] req_wdata;
   logic        ack;
   logic [31:0] rdata;

   int          n_chk = 0;
   int          n_bad = 0;
   int          lat = 0;
   int          hold = 0;
   int          cyc = 0;
   logic [31:0] m_cfg, m_l0, m_l1;

   int          n_tx;
   logic        t_wr   [NTX];
   logic [7:0]  t_port [NTX];
   logic [15:0] t_addr [NTX];
   logic [31:0] t_data [NTX];
   logic        t_pin  [NTX];
   int          t_cyc  [NTX];

   always #4 clk = ~clk;

   pcie_rst_seq #(
      .CLK_PER_MS (CPM),
      .SOC_PORT   (SOCP),
      .AFE_PORT   (AFEP),
      .CFG_ADDR   (CFGA),
      .LANE0_ADDR (L0A),
      .LANE1_ADDR (L1A)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .perst_n   (perst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_port  (req_port),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .ack       (ack),
      .rdata     (rdata),
      .done      (done)
   );

   assign ack = req_valid && (hold >= lat);

   always_comb begin
      rdata = 32'hDEAD_BEEF;
      if (req_port == SOCP && req_addr == CFGA) rdata = m_cfg;
      if (req_port == AFEP && req_addr == L0A)  rdata = m_l0;
      if (req_port == AFEP && req_addr == L1A)  rdata = m_l1;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (req_valid && ack) begin
         hold <= 0;
         if (req_write) begin
            if (req_port == SOCP && req_addr == CFGA) m_cfg <= req_wdata;
            if (req_port == AFEP && req_addr == L0A)  m_l0  <= req_wdata;
            if (req_port == AFEP && req_addr == L1A)  m_l1  <= req_wdata;
         end
      end else if (req_valid) begin
         hold <= hold + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && req_valid && ack) begin
         if (n_tx < NTX) begin
            t_wr[n_tx]   <= req_write;
            t_port[n_tx] <= req_port;
            t_addr[n_tx] <= req_addr;
            t_data[n_tx] <= req_write ? req_wdata : rdata;
            t_pin[n_tx]  <= perst_n;
            t_cyc[n_tx]  <= cyc;
         end
         n_tx <= n_tx + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_tx(input int i, input logic wr, input logic [7:0] p,
                           input logic [15:0] a, input logic [31:0] d, input logic pin);
      // R3 R4 R7 R9: kind, target and data of each transaction
      check($sformatf("R3 tx%0d kind", i), 32'(t_wr[i]), 32'(wr));
      check($sformatf("R9 tx%0d port", i), 32'(t_port[i]), 32'(p));
      check($sformatf("R9 tx%0d addr", i), 32'(t_addr[i]), 32'(a));
      check($sformatf("R4/R7 tx%0d data", i), t_data[i], d);
      check($sformatf("R2/R6 tx%0d perst_n", i), 32'(t_pin[i]), 32'(pin));
   endtask

   task automatic check_gap(input int i, input int ms);
      int g;
      g = t_cyc[i + 1] - t_cyc[i] - lat;
      // R5: idle window after a timed step
      check($sformatf("R5 gap after tx%0d in window", i),
            32'((g >= ms * CPM) && (g <= ms * CPM + 8)), 32'd1);
   endtask

   task automatic run_one(input int l, input logic [31:0] c0, input logic [31:0] li);
      logic [31:0] c1, c2, c3, c4, l1i;
      int          w;
      lat  = l;
      l1i  = li ^ 32'h5A5A_5A00;
      c1   = c0 | 32'h1;
      c2   = c1 | 32'h6;
      c3   = c2 | 32'h8;
      c4   = c3 | 32'h10;
      rst_n = 1'b0;
      m_cfg = c0; m_l0 = li; m_l1 = l1i;
      n_tx  = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1: idle after reset, no start yet
      check("R1 perst_n after reset", 32'(perst_n), 32'd1);
      check("R1 done after reset", 32'(done), 32'd0);
      check("R1 no request", 32'(req_valid) | 32'(n_tx), 32'd0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      // R2: pin low before any request
      check("R2 perst_n low early", 32'(perst_n), 32'd0);
      check("R2 no request yet", 32'(n_tx), 32'd0);
      w = 0;
      while (!done && w < 3000) begin
         @(negedge clk);
         w++;
      end
      check("R8 done reached", 32'(done), 32'd1);
      check("R8 transaction count", 32'(n_tx), 32'(NTX));
      if (n_tx == NTX) begin
         check_tx(0,  1'b0, SOCP, CFGA, c0, 1'b0);
         check_tx(1,  1'b1, SOCP, CFGA, c1, 1'b0);
         check_tx(2,  1'b0, SOCP, CFGA, c1, 1'b0);
         check_tx(3,  1'b1, SOCP, CFGA, c2, 1'b0);
         check_tx(4,  1'b0, SOCP, CFGA, c2, 1'b0);
         check_tx(5,  1'b1, SOCP, CFGA, c3, 1'b0);
         check_tx(6,  1'b0, SOCP, CFGA, c3, 1'b1);
         check_tx(7,  1'b1, SOCP, CFGA, c4, 1'b1);
         check_tx(8,  1'b0, AFEP, L0A,  li, 1'b1);
         check_tx(9,  1'b1, AFEP, L0A,  li & ~32'hC0, 1'b1);
         check_tx(10, 1'b0, AFEP, L1A,  l1i, 1'b1);
         check_tx(11, 1'b1, AFEP, L1A,  l1i & ~32'hC0, 1'b1);
         check_gap(1, 1);
         check_gap(3, 80);
         check_gap(5, 20);
      end
      // R8: a second start after done is ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      check("R8 no new requests", 32'(n_tx), 32'(NTX));
      check("R8 done stays high", 32'(done), 32'd1);
      check("R6 perst_n stays high", 32'(perst_n), 32'd1);
   endtask

   initial begin
      for (int l = 0; l < 4; l++) begin
         run_one(l, 32'h0000_0100, 32'hFFFF_FFFF);
         run_one(l, 32'hA5A5_0000, 32'h0000_00C0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule